// File: doc/BRIEF.md
# Transmit Queue-to-Channel Scheduler

This block decides which transmit queue supplies the next frame and which DMA channel carries it. Sixteen queues feed up to eight channels through a host-written binding table. Each queue is bound to exactly one channel, and a channel may collect several queues. Channels 0 to 3 are traffic classes ordered from background up to voice/management. Channel 7 is the command channel. Channels 4 to 6 take no traffic unless the host binds a queue to them.

For each channel that reports it can take a frame, a per-channel picker rotates round-robin over the queues bound to that channel that are both enabled and pending. A fixed-rank arbiter then chooses one channel. The command channel ranks first, then channels 3, 2, 1 and 0, then channels 6, 5 and 4. The winning queue and channel indices are registered and offered on a valid/ready output. An offered grant stays frozen until it is accepted.

Top module: `tqs_sched`

## Requirements
- R1: After reset the output is not valid while no queue is pending, and every queue starts enabled.
- R2: A configuration write stores a 4-bit status word for the addressed queue. Bits [2:0] hold the channel number and bit 3 holds the enable flag.
- R3: A queue whose enable flag is 0 is never granted, even when it is pending and its channel is ready.
- R4: A grant names a queue that was pending and bound to the granted channel, and that channel's ready input was 1.
- R5: Among channels that have candidates, channel 7 wins first. Channels 3, 2, 1 and 0 follow in that order, then channels 6, 5 and 4.
- R6: Within one channel, the queue after the one last granted on that channel (in increasing index order, wrapping from 15 to 0) gets the next grant, provided it is enabled and pending. Queues that are not enabled or not pending are skipped.
- R7: While the output is valid and ready is 0, the queue and channel indices stay constant. This holds even if the binding table is rewritten.
- R8: A table write applies to every selection made on a clock edge after the write edge.
- R9: After reset, queues 0 to 6 are bound to channels 0 to 6, and each queue q from 7 to 15 is bound to channel q mod 4.
- R10: When the output register is empty, a grant becomes valid one clock edge after a candidate appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Status word write strobe |
| cfg_queue_i | input | 4 | Queue addressed by the write |
| cfg_wdata_i | input | 4 | Status word: [2:0] channel, [3] enable |
| pend_i | input | 16 | Per-queue frame-pending flags |
| chan_rdy_i | input | 8 | Per-channel can-accept flags |
| grant_valid_o | output | 1 | Grant offered |
| grant_ready_i | input | 1 | Grant accepted |
| grant_queue_o | output | 4 | Granted queue index |
| grant_chan_o | output | 3 | Granted channel index |

## Verification
The bench builds the block with its defaults: 16 queues, 8 channels, 4 traffic classes and command channel 7. With these values the whole rank order is reachable, including the normally idle channels 4 to 6, and the default binding that folds queues 7 to 15 onto the traffic classes. Sixteen queues also let a channel hold three bound queues, so the round-robin pointer is seen wrapping from a high index back to queue 0.

// File: rtl/tqs_pkg.sv
package tqs_pkg;
  localparam int DEF_NUM_Q  = 16;
  localparam int DEF_NUM_CH = 8;
  localparam int DEF_NUM_TC = 4;
  localparam int DEF_CMD_CH = 7;

  // lower rank wins; command first, classes high to low, spare channels last
  function automatic int chan_rank(int c, int num_ch, int cmd_ch, int num_tc);
    if (c == cmd_ch) return 0;
    if (c < num_tc) return num_tc - c;
    return num_tc + (num_ch - c);
  endfunction

  function automatic int def_chan(int q, int num_ch, int num_tc);
    if (q < num_ch - 1) return q;
    return q % num_tc;
  endfunction
endpackage

// File: rtl/tqs_map_regs.sv
module tqs_map_regs #(
  parameter int NUM_Q  = tqs_pkg::DEF_NUM_Q,
  parameter int NUM_CH = tqs_pkg::DEF_NUM_CH,
  parameter int NUM_TC = tqs_pkg::DEF_NUM_TC,
  localparam int QW    = $clog2(NUM_Q),
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [QW-1:0]               queue_i,
  input  logic [CH_W:0]               wdata_i,
  output logic [NUM_Q-1:0][CH_W-1:0]  map_o,
  output logic [NUM_Q-1:0]            act_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int q = 0; q < NUM_Q; q++) begin
        map_o[q] <= CH_W'(tqs_pkg::def_chan(q, NUM_CH, NUM_TC));
        act_o[q] <= 1'b1;
      end
    end else if (we_i) begin
      map_o[queue_i] <= wdata_i[CH_W-1:0];
      act_o[queue_i] <= wdata_i[CH_W];
    end
  end
endmodule

// File: rtl/tqs_chan_pick.sv
module tqs_chan_pick #(
  parameter int NUM_Q = tqs_pkg::DEF_NUM_Q,
  localparam int QW   = $clog2(NUM_Q)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NUM_Q-1:0] elig_i,
  input  logic             rdy_i,
  input  logic             adv_i,
  output logic             req_o,
  output logic [QW-1:0]    pick_o
);
  logic [QW-1:0] ptr_q;
  logic          found;

  // scan from far to near so the nearest successor of ptr_q wins
  always_comb begin
    pick_o = ptr_q;
    found  = 1'b0;
    for (int k = NUM_Q; k >= 1; k--) begin
      if (elig_i[(int'(ptr_q) + k) % NUM_Q]) begin
        pick_o = QW'((int'(ptr_q) + k) % NUM_Q);
        found  = 1'b1;
      end
    end
    req_o = found & rdy_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= QW'(NUM_Q - 1);
    else if (adv_i) ptr_q <= pick_o;
  end
endmodule

// File: rtl/tqs_prio_arb.sv
module tqs_prio_arb #(
  parameter int NUM_CH = tqs_pkg::DEF_NUM_CH,
  parameter int NUM_TC = tqs_pkg::DEF_NUM_TC,
  parameter int CMD_CH = tqs_pkg::DEF_CMD_CH,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] req_i,
  output logic              any_o,
  output logic [CH_W-1:0]   win_o
);
  int best;
  always_comb begin
    any_o = 1'b0;
    win_o = '0;
    best  = NUM_CH + NUM_TC + 1;
    for (int c = 0; c < NUM_CH; c++) begin
      if (req_i[c] && tqs_pkg::chan_rank(c, NUM_CH, CMD_CH, NUM_TC) < best) begin
        best  = tqs_pkg::chan_rank(c, NUM_CH, CMD_CH, NUM_TC);
        win_o = CH_W'(c);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tqs_sched.sv
module tqs_sched #(
  parameter int NUM_Q  = tqs_pkg::DEF_NUM_Q,
  parameter int NUM_CH = tqs_pkg::DEF_NUM_CH,
  parameter int NUM_TC = tqs_pkg::DEF_NUM_TC,
  parameter int CMD_CH = tqs_pkg::DEF_CMD_CH,
  localparam int QW    = $clog2(NUM_Q),
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [QW-1:0]     cfg_queue_i,
  input  logic [CH_W:0]     cfg_wdata_i,
  input  logic [NUM_Q-1:0]  pend_i,
  input  logic [NUM_CH-1:0] chan_rdy_i,
  output logic              grant_valid_o,
  input  logic              grant_ready_i,
  output logic [QW-1:0]     grant_queue_o,
  output logic [CH_W-1:0]   grant_chan_o
);
  logic [NUM_Q-1:0][CH_W-1:0] map_q;
  logic [NUM_Q-1:0]           act_q;
  logic [NUM_CH-1:0]          chan_req;
  logic [QW-1:0]              chan_pick [NUM_CH];
  logic                       any_req;
  logic [CH_W-1:0]            win_ch;
  logic                       load;

  tqs_map_regs #(.NUM_Q(NUM_Q), .NUM_CH(NUM_CH), .NUM_TC(NUM_TC)) u_map (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .queue_i (cfg_queue_i),
    .wdata_i (cfg_wdata_i),
    .map_o   (map_q),
    .act_o   (act_q)
  );

  assign load = !grant_valid_o || grant_ready_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [NUM_Q-1:0] elig;
    for (genvar q = 0; q < NUM_Q; q++) begin : g_q
      assign elig[q] = act_q[q] && pend_i[q] && (map_q[q] == CH_W'(c));
    end
    tqs_chan_pick #(.NUM_Q(NUM_Q)) u_pick (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .elig_i (elig),
      .rdy_i  (chan_rdy_i[c]),
      .adv_i  (load && any_req && (win_ch == CH_W'(c))),
      .req_o  (chan_req[c]),
      .pick_o (chan_pick[c])
    );
  end

  tqs_prio_arb #(.NUM_CH(NUM_CH), .NUM_TC(NUM_TC), .CMD_CH(CMD_CH)) u_arb (
    .req_i (chan_req),
    .any_o (any_req),
    .win_o (win_ch)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_valid_o <= 1'b0;
      grant_queue_o <= '0;
      grant_chan_o  <= '0;
    end else if (load) begin
      grant_valid_o <= any_req;
      if (any_req) begin
        grant_queue_o <= chan_pick[win_ch];
        grant_chan_o  <= win_ch;
      end
    end
  end
endmodule

// File: rtl/tqs_sched_chk.sv
module tqs_sched_chk #(
  parameter int NUM_Q  = 16,
  parameter int NUM_CH = 8,
  parameter int CMD_CH = 7,
  localparam int QW    = $clog2(NUM_Q),
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       grant_valid_o,
  input logic                       grant_ready_i,
  input logic [QW-1:0]              grant_queue_o,
  input logic [CH_W-1:0]            grant_chan_o,
  input logic [NUM_Q-1:0]           pend_i,
  input logic [NUM_CH-1:0]          chan_rdy_i,
  input logic [NUM_Q-1:0]           act_q,
  input logic [NUM_Q-1:0][CH_W-1:0] map_q,
  input logic [NUM_CH-1:0]          chan_req
);
  logic                       held_d;
  logic [NUM_Q-1:0]           act_d, pend_d;
  logic [NUM_Q-1:0][CH_W-1:0] map_d;
  logic [NUM_CH-1:0]          rdy_d, req_d;
  logic                       fresh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_d <= 1'b0; act_d <= '0; pend_d <= '0;
      map_d  <= '0;   rdy_d <= '0; req_d  <= '0;
    end else begin
      held_d <= grant_valid_o && !grant_ready_i;
      act_d  <= act_q;  pend_d <= pend_i; map_d <= map_q;
      rdy_d  <= chan_rdy_i; req_d <= chan_req;
    end
  end

  assign fresh = grant_valid_o && !held_d;

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o && !grant_ready_i |=> grant_valid_o && $stable(grant_queue_o) && $stable(grant_chan_o)); // R7
  AST_GRANT_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fresh |-> act_d[grant_queue_o]); // R3
  AST_GRANT_MAPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fresh |-> pend_d[grant_queue_o] && map_d[grant_queue_o] == grant_chan_o); // R4
  AST_GRANT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fresh |-> rdy_d[grant_chan_o]); // R4
  AST_CMD_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fresh && req_d[CMD_CH] |-> grant_chan_o == CH_W'(CMD_CH)); // R5
  AST_IDLE_NO_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !held_d && req_d == '0 |-> !grant_valid_o); // R10
endmodule

bind tqs_sched tqs_sched_chk #(.NUM_Q(NUM_Q), .NUM_CH(NUM_CH), .CMD_CH(CMD_CH)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .grant_valid_o (grant_valid_o),
  .grant_ready_i (grant_ready_i),
  .grant_queue_o (grant_queue_o),
  .grant_chan_o  (grant_chan_o),
  .pend_i        (pend_i),
  .chan_rdy_i    (chan_rdy_i),
  .act_q         (act_q),
  .map_q         (map_q),
  .chan_req      (chan_req)
);

// File: tb/tb_tqs_sched.sv
`timescale 1ns/1ps
module tb_tqs_sched;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_queue = '0;
  logic [3:0]  cfg_wdata = '0;
  logic [15:0] pend = '0;
  logic [7:0]  rdy = '0;
  logic        g_valid;
  logic        g_ready = 1'b0;
  logic [3:0]  g_queue;
  logic [2:0]  g_chan;

  int checks = 0;
  int errors = 0;
  bit discard = 1'b0;
  bit done = 1'b0;
  logic [6:0] exp_q [$];
  string      tag_q [$];

  always #10 clk = ~clk;

  tqs_sched dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_queue_i(cfg_queue),
    .cfg_wdata_i(cfg_wdata), .pend_i(pend), .chan_rdy_i(rdy),
    .grant_valid_o(g_valid), .grant_ready_i(g_ready),
    .grant_queue_o(g_queue), .grant_chan_o(g_chan)
  );

  // monitor: compare each accepted grant with the scoreboard head
  always @(negedge clk) begin
    if (rst_n && g_valid && g_ready && !discard) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R4 unexpected grant q=%0d ch=%0d expected none", g_queue, g_chan);
      end else begin
        logic [6:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({g_queue, g_chan} != e) begin
          errors++;
          $display("FAIL %s grant q=%0d ch=%0d expected q=%0d ch=%0d",
                   t, g_queue, g_chan, e[6:3], e[2:0]);
        end
      end
    end
  end

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic cfg(int q, logic [3:0] w);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_queue = 4'(q); cfg_wdata = w;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic take(int q, int c, bit clr, string req);
    bit seen = 1'b0;
    exp_q.push_back({4'(q), 3'(c)});
    tag_q.push_back(req);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (g_valid) begin seen = 1'b1; break; end
    end
    if (!seen) begin
      checks++; errors++;
      $display("FAIL %s no grant, expected q=%0d ch=%0d", req, q, c);
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end else begin
      @(posedge clk); #1;
      g_ready = 1'b1;
      if (clr) pend[q] = 1'b0;
      @(posedge clk); #1;
      g_ready = 1'b0;
    end
  endtask

  task automatic idle(string req);
    repeat (5) @(negedge clk);
    chk(!g_valid, req, g_valid, 0);
  endtask

  task automatic flush();
    @(posedge clk); #1;
    discard = 1'b1; pend = '0; g_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1 g_ready = 1'b0; discard = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rdy = 8'hFF;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state, nothing pending
    idle("R1");

    // R10: one edge from candidate to valid; R9 default binding
    @(posedge clk); #1 pend = 16'(1 << 9);
    @(negedge clk);
    chk(!g_valid, "R10 before edge", g_valid, 0);
    @(negedge clk);
    chk(g_valid && g_queue == 9 && g_chan == 1, "R10 after edge", {g_queue, g_chan}, {4'd9, 3'd1});
    take(9, 1, 1, "R9");
    @(posedge clk); #1 pend = 16'(1 << 14);
    take(14, 2, 1, "R9");
    @(posedge clk); #1 pend = 16'(1 << 5);
    take(5, 5, 1, "R9");

    // R2: status word layout
    cfg(12, 4'b1110);
    @(posedge clk); #1 pend = 16'(1 << 12);
    take(12, 6, 1, "R2");

    // R3: disabled queue ignored
    cfg(12, 4'b0110);
    @(posedge clk); #1 pend = 16'(1 << 12);
    idle("R3");
    @(posedge clk); #1 pend = '0;

    // R4: channel ready gating
    cfg(10, 4'b1111);
    @(posedge clk); #1 rdy = 8'h7F; pend = 16'(1 << 10);
    idle("R4");
    @(posedge clk); #1 rdy = 8'hFF;
    take(10, 7, 1, "R4");

    // R5: rank order across channels
    @(posedge clk); #1 pend = 16'h045F;
    take(10, 7, 1, "R5");
    take(3, 3, 1, "R5");
    take(2, 2, 1, "R5");
    take(1, 1, 1, "R5");
    take(0, 0, 1, "R5");
    take(6, 6, 1, "R5");
    take(4, 4, 1, "R5");

    // R6: rotation within channel 0 (queues 0, 4, 8), last grant there was 0
    cfg(4, 4'b1000);
    @(posedge clk); #1 pend = 16'h0111;
    take(4, 0, 0, "R6");
    take(8, 0, 0, "R6");
    take(0, 0, 0, "R6");
    take(4, 0, 0, "R6");
    flush();

    // R7: held grant survives a rebinding; R8: next selection uses new binding
    @(posedge clk); #1 pend = 16'(1 << 5);
    repeat (2) @(negedge clk);
    chk(g_valid && g_queue == 5 && g_chan == 5, "R7 offered", {g_queue, g_chan}, {4'd5, 3'd5});
    cfg(5, 4'b1010);
    repeat (2) @(negedge clk);
    chk(g_valid && g_queue == 5 && g_chan == 5, "R7 held", {g_queue, g_chan}, {4'd5, 3'd5});
    take(5, 5, 0, "R7");
    take(5, 2, 1, "R8");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule